// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline and handles the one dependency that result forwarding cannot cover. That dependency arises when a load is in execute and the instruction right behind it, in decode, reads the register the load is about to fill. The block compares the load's destination index with both source indices of the decoding instruction. On a match it freezes the front of the pipeline for one cycle. It drops the write enables of the program counter and the fetch/decode pipeline register, so those two instructions stay where they are. It also replaces the decoded control word headed for the decode/execute register with all zeros, which puts a no-op bubble into execute.

The load and every instruction older than it keep moving, because the block touches neither them nor any later register. On the next cycle the bubble sits in the decode/execute register with its memory-read bit cleared, so the condition cannot hold again. The dependent instruction then issues and picks up the loaded value by forwarding. Apart from a saturating count of stall cycles, which exists for observation, the block is combinational.

Top module: `hzd_loaduse_ctrl`

## Requirements
- R1: A stall is raised when the execute-stage memory-read flag is 1, the execute destination index is nonzero, and it equals the decode instruction's first source index.
- R2: A stall is raised when the execute-stage memory-read flag is 1, the execute destination index is nonzero, and it equals the decode instruction's second source index.
- R3: With the execute-stage memory-read flag at 0, no stall is raised, whatever the register indices are.
- R4: An execute destination index of 0 never causes a stall.
- R5: During a stall both `pc_we` and `fd_we` are 0. Outside a stall both are 1.
- R6: During a stall every bit of `idex_ctrl` is 0. Outside a stall `idex_ctrl` equals `dec_ctrl` bit for bit.
- R7: `stall_cnt` is 0 after a synchronous reset. At each rising clock edge where a stall is present it rises by one, and it holds at its all-ones maximum instead of wrapping.
- R8: Bit `MEMRD_BIT` (default 0) of the control word is the memory-read flag. When `idex_ctrl` is registered into the execute stage and fed back as `ex_memrd`, a load followed by a dependent instruction stalls for exactly one cycle. During that cycle the decode instruction is held and the bubble's control word is zero, and the next cycle does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset for the stall counter |
| ex_memrd | input | 1 | Memory-read flag of the instruction in execute |
| ex_dst | input | REG_W | Destination register index of the instruction in execute |
| dec_src_a | input | REG_W | First source register index of the instruction in decode |
| dec_src_b | input | REG_W | Second source register index of the instruction in decode |
| dec_ctrl | input | CTRL_W | Control word decoded for the instruction in decode |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode pipeline register write enable |
| idex_ctrl | output | CTRL_W | Control word to be written into the decode/execute register |
| stall_cnt | output | CNT_W | Saturating count of stall cycles |

## Verification
Single-cycle patterns are driven one at a time to isolate each condition that triggers or blocks a stall. These cover a match on only the first source and a match on only the second, a match on both, and a match with the memory-read flag cleared. They also cover a register-0 load whose sources are also 0, and a near miss that differs in one index bit. Each pattern separates the terms of the detection condition and catches a missing or swapped term. A held hazard run of more than 255 cycles pushes the counter past its ceiling to show it saturates rather than wraps. A short closed-loop trace feeds the bubble back through a modelled decode/execute register, running a load, then a dependent use, then an independent instruction. It shows that the freeze ends on its own after exactly one cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Register index width of the instruction set.
    localparam int REG_W     = 5;
    // Width of the control word carried from decode into execute.
    localparam int CTRL_W    = 8;
    // Position of the memory-read flag inside the control word.
    localparam int MEMRD_BIT = 0;
    // Width of the observation stall counter.
    localparam int CNT_W     = 8;

    // Which source operands of the decoding instruction hit the load.
    typedef struct packed {
        logic hit_a;
        logic hit_b;
    } src_hit_t;

    // True when a register index names the hard-wired zero register.
    function automatic logic idx_is_zero(input logic [REG_W-1:0] idx);
        return idx == '0;
    endfunction

endpackage

// File: rtl/hzd_match.sv
module hzd_match
    import hzd_pkg::*;
(
    input  logic             memrd,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    output src_hit_t         hits
);

    logic live_load;

    // A load writing the zero register produces no value anyone waits on.
    assign live_load = memrd && !idx_is_zero(dst);

    always_comb begin
        hits.hit_a = live_load && (dst == src_a);
        hits.hit_b = live_load && (dst == src_b);
    end

endmodule

// File: rtl/hzd_bubble_mux.sv
module hzd_bubble_mux #(
    parameter int WIDTH = 8
) (
    input  logic             squash,
    input  logic [WIDTH-1:0] ctrl_in,
    output logic [WIDTH-1:0] ctrl_out
);

    // One gate per control bit: a single AND level, no wide mux tree.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign ctrl_out[i] = ctrl_in[i] & ~squash;
    end

endmodule

// File: rtl/hzd_stall_ctr.sv
module hzd_stall_ctr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/hzd_loaduse_ctrl.sv
module hzd_loaduse_ctrl
    import hzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_memrd,
    input  logic [REG_W-1:0]  ex_dst,
    input  logic [REG_W-1:0]  dec_src_a,
    input  logic [REG_W-1:0]  dec_src_b,
    input  logic [CTRL_W-1:0] dec_ctrl,
    output logic              pc_we,
    output logic              fd_we,
    output logic [CTRL_W-1:0] idex_ctrl,
    output logic [CNT_W-1:0]  stall_cnt
);

    src_hit_t hits;
    logic     freeze;

    hzd_match u_match (
        .memrd (ex_memrd),
        .dst   (ex_dst),
        .src_a (dec_src_a),
        .src_b (dec_src_b),
        .hits  (hits)
    );

    assign freeze = hits.hit_a | hits.hit_b;

    // Front of the pipeline holds; older stages are not touched here.
    assign pc_we = ~freeze;
    assign fd_we = ~freeze;

    hzd_bubble_mux #(.WIDTH(CTRL_W)) u_bubble (
        .squash   (freeze),
        .ctrl_in  (dec_ctrl),
        .ctrl_out (idex_ctrl)
    );

    hzd_stall_ctr #(.WIDTH(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .inc   (freeze),
        .count (stall_cnt)
    );

endmodule

// File: rtl/hzd_loaduse_ctrl_chk.sv
module hzd_loaduse_ctrl_chk
    import hzd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ex_memrd,
    input logic [REG_W-1:0]  ex_dst,
    input logic [REG_W-1:0]  dec_src_a,
    input logic [REG_W-1:0]  dec_src_b,
    input logic [CTRL_W-1:0] dec_ctrl,
    input logic              pc_we,
    input logic              fd_we,
    input logic [CTRL_W-1:0] idex_ctrl,
    input logic [CNT_W-1:0]  stall_cnt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    a_r1_src_a_hit: assert property (@(posedge clk) disable iff (rst)
        (ex_memrd && ex_dst != '0 && ex_dst == dec_src_a) |-> !pc_we);

    a_r2_src_b_hit: assert property (@(posedge clk) disable iff (rst)
        (ex_memrd && ex_dst != '0 && ex_dst == dec_src_b) |-> !pc_we);

    a_r3_no_load_no_stall: assert property (@(posedge clk) disable iff (rst)
        !ex_memrd |-> (pc_we && fd_we));

    a_r4_zero_dst_no_stall: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0) |-> (pc_we && fd_we));

    a_r5_enables_agree: assert property (@(posedge clk) disable iff (rst)
        pc_we == fd_we);

    a_r6_bubble_zero: assert property (@(posedge clk) disable iff (rst)
        !fd_we |-> (idex_ctrl == '0));

    a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
        fd_we |-> (idex_ctrl == dec_ctrl));

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && stall_cnt != CNT_TOP) |=> (stall_cnt == $past(stall_cnt) + 1'b1));

    a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
        pc_we |=> $stable(stall_cnt));

    a_r7_count_saturate: assert property (@(posedge clk) disable iff (rst)
        (stall_cnt == CNT_TOP) |=> (stall_cnt == CNT_TOP));

endmodule

bind hzd_loaduse_ctrl hzd_loaduse_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ex_memrd  (ex_memrd),
    .ex_dst    (ex_dst),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .dec_ctrl  (dec_ctrl),
    .pc_we     (pc_we),
    .fd_we     (fd_we),
    .idex_ctrl (idex_ctrl),
    .stall_cnt (stall_cnt)
);

// File: tb/hzd_loaduse_ctrl_tb.sv
`timescale 1ns/1ps
module hzd_loaduse_ctrl_tb;
    import hzd_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ex_memrd = 1'b0;
    logic [REG_W-1:0]  ex_dst = '0;
    logic [REG_W-1:0]  dec_src_a = '0;
    logic [REG_W-1:0]  dec_src_b = '0;
    logic [CTRL_W-1:0] dec_ctrl = '0;
    logic              pc_we, fd_we;
    logic [CTRL_W-1:0] idex_ctrl;
    logic [CNT_W-1:0]  stall_cnt;

    int errors = 0;
    int checks = 0;
    int m_cnt  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hzd_loaduse_ctrl u_dut (
        .clk(clk), .rst(rst), .ex_memrd(ex_memrd), .ex_dst(ex_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_ctrl(dec_ctrl),
        .pc_we(pc_we), .fd_we(fd_we), .idex_ctrl(idex_ctrl), .stall_cnt(stall_cnt)
    );

    // Reference: behavioural statement of the stall rule.
    function automatic bit ref_stall(bit memrd, int dst, int a, int b);
        if (!memrd) return 0;
        if (dst == 0) return 0;
        return (dst == a) || (dst == b);
    endfunction

    // Reference stall counter, saturating at the CNT_W ceiling.
    always @(posedge clk) begin
        if (rst) m_cnt = 0;
        else if (ref_stall(ex_memrd, int'(ex_dst), int'(dec_src_a), int'(dec_src_b))
                 && m_cnt < (1 << CNT_W) - 1)
            m_cnt = m_cnt + 1;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one decode cycle at the falling edge, compare just after.
    task automatic step(bit memrd, int dst, int a, int b, int ctrl, string req);
        bit exp_stall;
        longint exp_ctrl;
        @(negedge clk);
        ex_memrd  = memrd;
        ex_dst    = REG_W'(dst);
        dec_src_a = REG_W'(a);
        dec_src_b = REG_W'(b);
        dec_ctrl  = CTRL_W'(ctrl);
        #1;
        exp_stall = ref_stall(memrd, dst, a, b);
        exp_ctrl  = exp_stall ? 0 : longint'(CTRL_W'(ctrl));
        chk(pc_we == !exp_stall, req, "pc_we", pc_we, !exp_stall);
        chk(fd_we == !exp_stall, "R5", "fd_we", fd_we, !exp_stall);
        chk(idex_ctrl == CTRL_W'(exp_ctrl), "R6", "idex_ctrl", idex_ctrl, exp_ctrl);
        chk(int'(stall_cnt) == m_cnt, "R7", "stall_cnt", stall_cnt, m_cnt);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    // Closed-loop trace state: program ROM of decode entries.
    typedef struct {
        bit memrd;
        int dst;
        int a;
        int b;
        int ctrl;
    } insn_t;

    initial begin
        insn_t prog[4];
        int fd_ix;
        bit idex_memrd;
        int idex_dst;
        int stalls;
        int stall_at;
        bit cur_we;
        logic [CTRL_W-1:0] cur_ctrl;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(stall_cnt == '0, "R7", "reset stall_cnt", stall_cnt, 0);
        chk(pc_we && fd_we, "R5", "reset enables", pc_we & fd_we, 1);

        // Single-cycle patterns.
        step(1, 3, 3, 9, 8'hA5, "R1");   // first source only
        step(1, 4, 1, 4, 8'h5A, "R2");   // second source only
        step(1, 7, 7, 7, 8'hFF, "R1");   // both sources
        step(0, 6, 6, 6, 8'h3C, "R3");   // match, not a load
        step(1, 0, 0, 0, 8'h81, "R4");   // zero register
        step(1, 8, 9, 10, 8'h77, "R3");  // near miss, one bit off
        step(0, 0, 1, 2, 8'h12, "R6");   // plain pass-through
        step(1, 31, 31, 0, 8'hC3, "R2");

        // Saturation: hold a hazard well past the counter ceiling.
        for (int i = 0; i < 260; i++) step(1, 2, 2, 5, 8'h0F, "R7");
        chk(stall_cnt == '1, "R7", "saturated stall_cnt", stall_cnt, (1 << CNT_W) - 1);
        step(0, 2, 2, 5, 8'h0F, "R7");

        // Reset clears the counter again before the trace.
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk(stall_cnt == '0, "R7", "re-reset stall_cnt", stall_cnt, 0);

        // Trace: load r3, dependent use of r3, independent op, nop.
        prog[0] = '{1, 3, 1, 0, 8'h03};
        prog[1] = '{0, 4, 3, 5, 8'h42};
        prog[2] = '{0, 8, 6, 7, 8'h22};
        prog[3] = '{0, 0, 0, 0, 8'h00};
        fd_ix = 0; idex_memrd = 0; idex_dst = 0; stalls = 0; stall_at = -1;
        for (int cyc = 0; cyc < 6; cyc++) begin
            insn_t cur;
            cur = prog[fd_ix < 4 ? fd_ix : 3];
            step(idex_memrd, idex_dst, cur.a, cur.b, cur.ctrl, "R8");
            cur_we   = fd_we;
            cur_ctrl = idex_ctrl;
            if (!cur_we) begin
                stalls++;
                if (stall_at < 0) stall_at = cyc;
                chk(cur_ctrl == '0, "R8", "bubble control", cur_ctrl, 0);
            end
            @(posedge clk);
            // Modelled decode/execute register and fetch pointer.
            idex_memrd = cur_ctrl[MEMRD_BIT];
            idex_dst   = cur.dst;
            if (cur_we && fd_ix < 3) fd_ix++;
            if (cyc == 1) chk(fd_ix == 1, "R8", "held decode index", fd_ix, 1);
            if (cyc == 2) chk(fd_ix == 2, "R8", "advanced after stall", fd_ix, 2);
        end
        chk(stalls == 1, "R8", "stall cycles in trace", stalls, 1);
        chk(stall_at == 1, "R8", "stall cycle position", stall_at, 1);
        #1;
        chk(stall_cnt == 8'd1, "R8", "trace stall_cnt", stall_cnt, 1);

        finish_run();
    end

endmodule